// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Prescaler

This block holds an 8-bit timer/counter, a watchdog counter and one 8-bit prescaler that serves only one of the two at a time. A control byte picks where the timer gets its count events. It can use the instruction clock, which is one pulse every four system clocks. It can also use an external count pin, on the pin's rising edge or its falling edge. The same byte decides which counter the prescaler serves, sets a 3-bit division ratio and turns the watchdog on or off. The prescaler counts down. Its current contents can be read on a port, as can the timer value and the control byte itself.

When the prescaler serves the timer, it divides the timer's count events. The watchdog then takes every raw tick. When it serves the watchdog, it divides the watchdog ticks, and the timer counts every source event. The watchdog raises a one-cycle time-out pulse on its terminal step. A clear strobe holds the watchdog off.

There are three small state machines. The instruction-clock phase machine moves PH_0 → PH_1 → PH_2 → PH_3 → PH_0 and gives a tick in PH_3. The pin-level machine has two states. It moves PIN_LO → PIN_HI when the synchronized pin reads high, which is a rising event. It moves PIN_HI → PIN_LO when the pin reads low, which is a falling event. The watchdog machine has two states. It moves WD_RUN → WD_BITE on the terminal step. It moves WD_BITE → WD_RUN on the next cycle unless another terminal step arrives. The time-out output is high only in WD_BITE.

Top module: `tmr_wdt_core`

## Requirements
- R1: After reset, the outputs are: timer 0, prescaler 0, overflow flag 0, time-out 0, and control readback 0x08.
- R2: Writing the control byte takes effect at the clock edge where the write strobe is high. The field layout is:
  - bits 2..0: ratio select
  - bit 3: prescaler serves the watchdog when 1, the timer when 0
  - bit 4: count on the falling pin edge when 1, the rising edge when 0
  - bit 5: timer counts pin events when 1, the instruction clock when 0
  - bit 6: watchdog enable
  - bit 7: always reads back 0
- R3: With the instruction clock as the source and the prescaler on the watchdog, the timer advances once every 4 clocks. The first advance comes on the 4th edge after reset.
- R4: The count pin passes through two synchronizing flops. A selected edge that changes the pin between two clock edges advances the timer on the 3rd following edge. The edge that was not selected has no effect.
- R5: With the prescaler on the timer, the timer advances once per 2^(ratio+1) source events, which gives 1:2 up to 1:256.
- R6: With the prescaler on the watchdog, the watchdog steps once per 2^ratio enabled ticks, which gives 1:1 up to 1:128.
- R7: The prescaler starts from 0 after a clear and drops by one for each input event, wrapping from 0x00 to 0xFF. A divided event is produced when the low bits of the new value, as many bits as the ratio's power of two, are all zero.
- R8: Any control write clears the prescaler. The watchdog clear strobe also clears it when the prescaler serves the watchdog. The strobe leaves it unchanged when the prescaler serves the timer.
- R9: The timer wraps from 0xFF to 0x00 and sets a sticky overflow flag on that wrap. The overflow-clear input drops the flag, and a wrap in the same cycle wins.
- R10: The watchdog times out on its 16th step since its last clear or time-out. The time-out pulse lasts exactly one cycle, on the cycle after that step.
- R11: While the watchdog is disabled, its ticks are ignored. The watchdog count holds, no time-out occurs, and a prescaler serving the watchdog does not move.
- R12: The watchdog clear strobe restarts the watchdog count and overrides a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| cnt_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog tick, one cycle per tick |
| wdt_clr | input | 1 | Watchdog clear strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_value | output | 8 | Timer readback |
| psc_value | output | 8 | Prescaler counter readback |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_bite | output | 1 | Watchdog time-out pulse |

## Verification
Every output comes from a register, so the timing is fixed:
- Control readback, timer, prescaler and overflow change at the edge that sees their cause.
- A pin change reaches the timer three edges after the change.
- The time-out pulse appears one cycle after the terminal step.

A behavioural model in the bench advances on the same edges and is compared with every output in the middle of each low clock phase. Directed checks wait an exact number of falling edges chosen by these latencies. Examples are two checks on either side of the pin's third edge, and one check on each side of the 64th watchdog tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTL_W = 8;
    localparam int SEL_W = 3;

    typedef struct packed {
        logic             rsvd;
        logic             wd_en;
        logic             src_pin;
        logic             edge_fall;
        logic             psc_to_wd;
        logic [SEL_W-1:0] ratio;
    } tmr_ctl_t;

    localparam tmr_ctl_t CTL_RESET = '{
        rsvd:      1'b0,
        wd_en:     1'b0,
        src_pin:   1'b0,
        edge_fall: 1'b0,
        psc_to_wd: 1'b1,
        ratio:     '0
    };

    typedef enum logic [1:0] {PH_0, PH_1, PH_2, PH_3} insn_phase_e;

    typedef enum logic {PIN_LO, PIN_HI} pin_level_e;

    typedef enum logic {WD_RUN, WD_BITE} wd_state_e;

endpackage

// File: rtl/tmr_insn_clk.sv
module tmr_insn_clk
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic insn_tick
);

    insn_phase_e phase_q;
    insn_phase_e phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_0;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_0: phase_d = PH_1;
            PH_1: phase_d = PH_2;
            PH_2: phase_d = PH_3;
            PH_3: phase_d = PH_0;
        endcase
    end

    always_comb begin
        insn_tick = (phase_q == PH_3);
    end

    // R3: one tick per four clocks, never two in a row
    a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        insn_tick |=> !insn_tick);

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic edge_fall,
    output logic pin_evt
);

    logic [1:0] sync_q;
    pin_level_e lvl_q;
    pin_level_e lvl_d;
    logic       rise;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_async};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= PIN_LO;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        lvl_d = lvl_q;
        rise  = 1'b0;
        fall  = 1'b0;
        unique case (lvl_q)
            PIN_LO: begin
                if (sync_q[1]) begin
                    lvl_d = PIN_HI;
                    rise  = 1'b1;
                end
            end
            PIN_HI: begin
                if (!sync_q[1]) begin
                    lvl_d = PIN_LO;
                    fall  = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        pin_evt = edge_fall ? fall : rise;
    end

    // R4: a rising event reflects the pin as sampled two edges earlier
    a_r4_rise_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt && !edge_fall) |-> $past(pin_async, 2));

    // R4: a falling event reflects a low pin two edges earlier
    a_r4_fall_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt && edge_fall) |-> !$past(pin_async, 2));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_in,
    input  logic [SEL_W-1:0] ratio,
    input  logic             to_wd,
    output logic [PSC_W-1:0] cnt_q,
    output logic             step_out
);

    localparam int TAP_W = $clog2(PSC_W + 1);

    logic [TAP_W-1:0] tap_bits;
    logic [PSC_W-1:0] tap_mask;
    logic [PSC_W-1:0] cnt_dec;

    always_comb begin
        if (to_wd) begin
            tap_bits = TAP_W'(ratio);
        end else begin
            tap_bits = TAP_W'(ratio) + TAP_W'(1);
        end
    end

    for (genvar i = 0; i < PSC_W; i++) begin : g_tap
        assign tap_mask[i] = (TAP_W'(i) < tap_bits);
    end

    assign cnt_dec  = cnt_q - PSC_W'(1);
    assign step_out = step_in && !clr && ((cnt_dec & tap_mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step_in) begin
            cnt_q <= cnt_dec;
        end
    end

    // R8: a clear leaves the counter at zero
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R7: each input event lowers the count by exactly one
    a_r7_down_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && !clr) |=> (cnt_q == $past(cnt_q) - PSC_W'(1)));

    // R7: without events or clear the count holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_in && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tmr_pkg::*;
#(
    parameter int TERM = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic step,
    input  logic clr,
    output logic bite
);

    localparam int CNT_W = $clog2(TERM);

    logic [CNT_W-1:0] cnt_q;
    wd_state_e        st_q;
    wd_state_e        st_d;
    logic             at_term;
    logic             fire;

    assign at_term = (cnt_q == CNT_W'(TERM - 1));
    assign fire    = enable && step && !clr && at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (enable && step) begin
            if (at_term) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WD_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            WD_RUN:  st_d = fire ? WD_BITE : WD_RUN;
            WD_BITE: st_d = fire ? WD_BITE : WD_RUN;
        endcase
    end

    always_comb begin
        bite = (st_q == WD_BITE);
    end

    // R10: the time-out pulse is a single cycle
    a_r10_single_bite: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> !bite);

    // R11: a disabled watchdog holds its count
    a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clr) |=> ($stable(cnt_q) && !bite));

    // R12: the clear strobe restarts the count and blocks a time-out
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !bite));

endmodule

// File: rtl/tmr_wdt_core.sv
module tmr_wdt_core
    import tmr_pkg::*;
#(
    parameter int TMR_W    = 8,
    parameter int PSC_W    = 8,
    parameter int WDT_TERM = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             cnt_pin,
    input  logic             wdt_tick,
    input  logic             wdt_clr,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] tmr_value,
    output logic [PSC_W-1:0] psc_value,
    output logic             tmr_ovf,
    output logic             wdt_bite
);

    localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

    tmr_ctl_t         ctl_q;
    tmr_ctl_t         ctl_in;
    logic             insn_tick;
    logic             pin_evt;
    logic             src_tick;
    logic             psc_in;
    logic             psc_clr;
    logic             psc_step;
    logic             tmr_step;
    logic             wd_step;
    logic [TMR_W-1:0] tmr_q;
    logic             ovf_q;

    always_comb begin
        ctl_in      = tmr_ctl_t'(ctl_wdata);
        ctl_in.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_wr) begin
            ctl_q <= ctl_in;
        end
    end

    tmr_insn_clk u_insn (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_tick (insn_tick)
    );

    tmr_pin_sync u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cnt_pin),
        .edge_fall (ctl_q.edge_fall),
        .pin_evt   (pin_evt)
    );

    always_comb begin
        src_tick = ctl_q.src_pin ? pin_evt : insn_tick;
        psc_in   = ctl_q.psc_to_wd ? (wdt_tick && ctl_q.wd_en) : src_tick;
        psc_clr  = ctl_wr || (wdt_clr && ctl_q.psc_to_wd);
        tmr_step = ctl_q.psc_to_wd ? src_tick : psc_step;
        wd_step  = ctl_q.psc_to_wd ? psc_step : wdt_tick;
    end

    tmr_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (psc_clr),
        .step_in  (psc_in),
        .ratio    (ctl_q.ratio),
        .to_wd    (ctl_q.psc_to_wd),
        .cnt_q    (psc_value),
        .step_out (psc_step)
    );

    tmr_wdog #(
        .TERM (WDT_TERM)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctl_q.wd_en),
        .step   (wd_step),
        .clr    (wdt_clr),
        .bite   (wdt_bite)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tmr_step) begin
            tmr_q <= tmr_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (tmr_step && tmr_q == TMR_MAX) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    assign ctl_rdata = ctl_q;
    assign tmr_value = tmr_q;
    assign tmr_ovf   = ovf_q;

    // R9: the wrap lands on zero with the flag raised
    a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_step && tmr_q == TMR_MAX) |=> (tmr_value == '0 && tmr_ovf));

    // R9: the flag stays up until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !ovf_clr) |=> tmr_ovf);

    // R5: the timer never moves by more than one per cycle
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tmr_value == $past(tmr_value) ||
                  tmr_value == $past(tmr_value) + TMR_W'(1)));

    // R2: a write shows up on the readback at the next cycle
    a_r2_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata[CTL_W-2:0] == $past(ctl_wdata[CTL_W-2:0])));

endmodule

// File: tb/tmr_wdt_core_bench.sv
module tmr_wdt_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TERM       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       cnt_pin = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] ctl_rdata;
    logic [7:0] tmr_value;
    logic [7:0] psc_value;
    logic       tmr_ovf;
    logic       wdt_bite;

    int    checks = 0;
    int    errors = 0;
    int    bites_seen = 0;
    bit    running = 1'b1;
    string cur_req = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_wdt_core #(
        .TMR_W    (8),
        .PSC_W    (8),
        .WDT_TERM (TERM)
    ) u_tmr_wdt_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .cnt_pin   (cnt_pin),
        .wdt_tick  (wdt_tick),
        .wdt_clr   (wdt_clr),
        .ovf_clr   (ovf_clr),
        .tmr_value (tmr_value),
        .psc_value (psc_value),
        .tmr_ovf   (tmr_ovf),
        .wdt_bite  (wdt_bite)
    );

    // behavioural reference, advanced on every rising edge
    int m_ph, m_s1, m_s2, m_lvl, m_psc, m_tmr, m_ovf, m_wcnt, m_bite, m_ctl;

    always @(posedge clk) begin
        int insn, ev, src, asg, en, k, pin_in, clr, dec, pout, tstep, wstep;
        if (!rst_n) begin
            m_ph = 0; m_s1 = 0; m_s2 = 0; m_lvl = 0;
            m_psc = 0; m_tmr = 0; m_ovf = 0; m_wcnt = 0; m_bite = 0;
            m_ctl = 8'h08;
        end else begin
            insn = (m_ph == 3) ? 1 : 0;
            if (m_ctl[4]) ev = (m_lvl == 1 && m_s2 == 0) ? 1 : 0;
            else          ev = (m_lvl == 0 && m_s2 == 1) ? 1 : 0;
            src = m_ctl[5] ? ev : insn;
            asg = m_ctl[3];
            en  = m_ctl[6];
            k   = asg ? (m_ctl & 7) : (m_ctl & 7) + 1;
            pin_in = asg ? ((wdt_tick && en) ? 1 : 0) : src;
            clr = (ctl_wr || (wdt_clr && asg)) ? 1 : 0;
            dec = (m_psc + 255) % 256;
            pout = (pin_in == 1 && clr == 0 && (dec % (1 << k)) == 0) ? 1 : 0;
            if (clr == 1) m_psc = 0;
            else if (pin_in == 1) m_psc = dec;
            tstep = asg ? src : pout;
            if (tstep == 1 && m_tmr == 255) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (tstep == 1) m_tmr = (m_tmr + 1) % 256;
            wstep = (en == 1 && (asg ? pout : int'(wdt_tick)) == 1) ? 1 : 0;
            m_bite = 0;
            if (wdt_clr) m_wcnt = 0;
            else if (wstep == 1) begin
                if (m_wcnt == TERM - 1) begin
                    m_wcnt = 0;
                    m_bite = 1;
                end else begin
                    m_wcnt = m_wcnt + 1;
                end
            end
            if (ctl_wr) m_ctl = ctl_wdata & 8'h7F;
            m_ph  = (m_ph + 1) % 4;
            m_lvl = m_s2;
            m_s2  = m_s1;
            m_s1  = cnt_pin ? 1 : 0;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk("ctl_rdata", int'(ctl_rdata), m_ctl);
            chk("tmr_value", int'(tmr_value), m_tmr);
            chk("psc_value", int'(psc_value), m_psc);
            chk("tmr_ovf", int'(tmr_ovf), m_ovf);
            chk("wdt_bite", int'(wdt_bite), m_bite);
            if (wdt_bite) bites_seen++;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        wdt_clr = 1'b1;
        @(negedge clk);
        wdt_clr = 1'b0;
    endtask

    task automatic wd_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wdt_tick = 1'b1;
            @(negedge clk);
            wdt_tick = 1'b0;
        end
    endtask

    task automatic pin_toggles(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_pin = ~cnt_pin;
            cycles(gap);
        end
    endtask

    initial begin
        int t0;
        int p0;
        int b0;
        // R1: reset values
        cur_req = "R1";
        cycles(3);
        chk("reset ctl", int'(ctl_rdata), 8'h08);
        chk("reset tmr", int'(tmr_value), 0);
        chk("reset psc", int'(psc_value), 0);
        chk("reset ovf", int'(tmr_ovf), 0);
        chk("reset bite", int'(wdt_bite), 0);
        rst_n = 1'b1;

        // R3: instruction clock gives one count per four clocks
        cur_req = "R3";
        cycles(40);
        chk("tmr after 40 clocks", int'(tmr_value), 10);

        // R2: control layout and reserved bit
        cur_req = "R2";
        wr_ctl(8'hFF);
        chk("ctl readback", int'(ctl_rdata), 8'h7F);
        cycles(20);

        // R4: pin events through the synchronizer, rising edge
        cur_req = "R4";
        wr_ctl(8'h28);
        t0 = int'(tmr_value);
        cnt_pin = 1'b1;
        cycles(2);
        chk("tmr before third edge", int'(tmr_value), t0);
        cycles(1);
        chk("tmr on third edge", int'(tmr_value), (t0 + 1) % 256);
        cnt_pin = 1'b0;
        cycles(5);
        chk("falling edge ignored", int'(tmr_value), (t0 + 1) % 256);
        pin_toggles(20, 2);
        wr_ctl(8'h38);
        pin_toggles(20, 3);
        pin_toggles(10, 0);

        // R5: prescaler on the timer, 1:2 then 1:8
        cur_req = "R5";
        wr_ctl(8'h00);
        t0 = int'(tmr_value);
        cycles(16);
        chk("1:2 over 16 clocks", int'(tmr_value), (t0 + 2) % 256);
        cycles(100);
        wr_ctl(8'h02);
        cycles(200);

        // R7: down counter value, 1:256
        cur_req = "R7";
        wr_ctl(8'h07);
        chk("psc after write", int'(psc_value), 0);
        cycles(8);
        chk("psc after two ticks", int'(psc_value), 254);
        cycles(1100);

        // R8: clear rules
        cur_req = "R8";
        wr_ctl(8'h22);
        pin_toggles(6, 3);
        cycles(4);
        p0 = int'(psc_value);
        chk("psc after three pin rises", p0, 253);
        pulse_clr();
        chk("strobe leaves timer prescaler", int'(psc_value), p0);
        wr_ctl(8'h4B);
        wd_ticks(5);
        chk("psc after five ticks", int'(psc_value), 251);
        pulse_clr();
        chk("strobe clears watchdog prescaler", int'(psc_value), 0);

        // R11: disabled watchdog ignores ticks
        cur_req = "R11";
        wr_ctl(8'h0B);
        b0 = bites_seen;
        wd_ticks(40);
        chk("psc held while disabled", int'(psc_value), 0);
        chk("no bite while disabled", bites_seen - b0, 0);

        // R6: watchdog step every 4 ticks, time-out after 64 ticks
        cur_req = "R6";
        wr_ctl(8'h4A);
        pulse_clr();
        wdt_tick = 1'b1;
        cycles(63);
        chk("no bite before 64 ticks", int'(wdt_bite), 0);
        cycles(1);
        chk("bite on 64th tick", int'(wdt_bite), 1);
        cur_req = "R10";
        cycles(1);
        chk("bite lasts one cycle", int'(wdt_bite), 0);
        wdt_tick = 1'b0;

        // R12: clear strobe keeps the watchdog from biting
        cur_req = "R12";
        wr_ctl(8'h48);
        pulse_clr();
        b0 = bites_seen;
        wdt_tick = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cycles(9);
            wdt_clr = 1'b1;
            @(negedge clk);
            wdt_clr = 1'b0;
        end
        chk("no bite with periodic clear", bites_seen - b0, 0);
        cycles(16);
        wdt_tick = 1'b0;
        cycles(2);
        chk("bite once clear stops", bites_seen - b0, 1);

        // R9: overflow flag
        cur_req = "R9";
        wr_ctl(8'h08);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        cycles(1100);
        chk("flag after wrap", int'(tmr_ovf), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("flag after clear", int'(tmr_ovf), 0);

        // mixed traffic against the model
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cnt_pin  = ($urandom % 4) == 0 ? ~cnt_pin : cnt_pin;
            wdt_tick = ($urandom % 2) == 0;
            wdt_clr  = ($urandom % 40) == 0;
            ovf_clr  = ($urandom % 16) == 0;
            ctl_wr   = ($urandom % 100) == 0;
            ctl_wdata = 8'($urandom);
        end
        @(negedge clk);
        ctl_wr = 1'b0; wdt_clr = 1'b0; ovf_clr = 1'b0; wdt_tick = 1'b0;
        cycles(2);

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (running) begin
            running = 1'b0;
            checks++;
            errors++;
            $display("FAIL %s watchdog expired actual 1 expected 0", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule